// File: doc/BRIEF.md
# Phase-Based Word-Granular L1 Coherence Controller

This block is the coherence controller of one core's private first-level cache. The coherence scheme relies on software that declares, for each parallel phase, which memory regions may be written. Each cached word holds its data, a small region id, a touched flag and one of three stable states: Invalid, Valid or Registered. The protocol has no transient states.

A core load that misses sends a fill request to the shared level. The word becomes Valid when the fill data returns. A load that hits returns the stored data. A core store writes the word locally, marks it Registered and sends a registration request, carrying this core's id, to the shared level. An access to a word whose registration has not yet been acknowledged stalls the core until the acknowledgement arrives.

The controller never receives invalidations and never sends invalidation acknowledgements. Stale data is removed at the end of each phase instead. A phase-end command carries a bitmask of the regions written in that phase. The controller drops every Valid word that lies in one of those regions unless the core read that word during the phase. In the same cycle it clears all touched flags. A one-cycle done pulse follows. Coherence is tracked per word, so stores to neighbouring words never disturb one another.

Top module: `l1_phase_coh`

## Requirements
- R1: After reset every word is Invalid, `core_req_ready` is 1 and `core_resp_valid`, `fill_req_valid`, `reg_req_valid` and `phase_end_done` are 0.
- R2: A load accepted on an Invalid word raises `fill_req_valid` with `fill_req_addr` in the following cycle, and no response in that cycle. The cycle after `fill_rsp_valid`, `core_resp_valid` carries the fill data, and the word is Valid and touched.
- R3: A load accepted on a Valid or Registered word raises `core_resp_valid` with the stored data in the following cycle, sets the word's touched flag and raises no fill request.
- R4: A store accepted in any state writes the data and region and makes the word Registered. The cycle after acceptance `core_resp_valid` carries the store data. If the word was not already Registered, `reg_req_valid` is raised in that same cycle with the address and `reg_req_core` equal to the core id; if it was already Registered, no request is raised.
- R5: While a registration for the requested word awaits its acknowledgement, `core_req_ready` is 0. It returns to 1 in the cycle after `reg_ack_valid` names that word.
- R6: On a phase-end sweep a word becomes Invalid exactly when it is Valid, not touched, and the mask bit indexed by its region id is 1. Registered words, touched words and words in unmasked regions keep their state and data.
- R7: The sweep clears every touched flag. A Valid word that was read in one phase but not in the next is therefore dropped by the second phase end when its region is in the mask.
- R8: A `phase_end_valid` pulse is latched. The cycle after it `core_req_ready` is 0, and the cycle after that `phase_end_done` is 1 for one cycle, with no core response and no fill request in that cycle.
- R9: `fill_req_valid` and `reg_req_valid` are never 1 in the same cycle, and no new core request is accepted while a fill is outstanding.
- R10: A store or fill to one word leaves the state and data of every other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Core request present |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | AW | Word index |
| core_req_wdata | input | DW | Store data |
| core_req_region | input | RW | Region id of the accessed word |
| core_req_ready | output | 1 | Request accepted at this edge when valid |
| core_resp_valid | output | 1 | Load data or store completion |
| core_resp_data | output | DW | Returned data |
| fill_req_valid | output | 1 | Fill request to the shared level |
| fill_req_addr | output | AW | Fill word index |
| fill_rsp_valid | input | 1 | Fill data arriving |
| fill_rsp_data | input | DW | Fill data |
| reg_req_valid | output | 1 | Registration request |
| reg_req_addr | output | AW | Registered word index |
| reg_req_core | output | CIDW | This core's id |
| reg_ack_valid | input | 1 | Registration acknowledgement |
| reg_ack_addr | input | AW | Acknowledged word index |
| phase_end_valid | input | 1 | Phase-end command pulse |
| phase_end_mask | input | NREG | Written-region mask, bit i = region id i |
| phase_end_done | output | 1 | Sweep completed |

## Verification
Two functions can fall in the same cycle: a registration acknowledgement and the phase-end sweep. The bench provokes this by presenting `reg_ack_valid` for a freshly stored word together with `phase_end_valid`. The acknowledgement then lands while the sweep command is latched. The result is judged at the ports: the stored word must still hit with its data after the sweep, and a new access to it must not stall. A random mix of loads, stores, acknowledgements and masked phase ends runs against a bench model that predicts each fill, hit, registration and invalidation.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        W_INV = 2'd0,
        W_VAL = 2'd1,
        W_REG = 2'd2
    } wstate_e;

    typedef enum logic {
        C_IDLE = 1'b0,
        C_FILL = 1'b1
    } cstate_e;

    // A word is dropped at phase end only when it holds a clean copy that the
    // core did not read and that another core may have written.
    function automatic logic sweep_kills(wstate_e st, logic touched, logic in_mask);
        return (st == W_VAL) && !touched && in_mask;
    endfunction

endpackage

// File: rtl/coh_word_array.sv
module coh_word_array
    import coh_pkg::*;
#(
    parameter int NWORDS = 16,
    parameter int DW     = 32,
    parameter int NREG   = 4,
    localparam int AW    = $clog2(NWORDS),
    localparam int RW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_addr,
    output wstate_e         rd_state,
    output logic [DW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  wstate_e         wr_state,
    input  logic [DW-1:0]   wr_data,
    input  logic [RW-1:0]   wr_region,
    input  logic            touch_en,
    input  logic [AW-1:0]   touch_addr,
    input  logic            sweep_en,
    input  logic [NREG-1:0] sweep_mask
);

    typedef struct packed {
        wstate_e       st;
        logic          tch;
        logic [RW-1:0] rg;
        logic [DW-1:0] dat;
    } word_t;

    wstate_e       st_vec  [NWORDS];
    logic [DW-1:0] dat_vec [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        word_t w_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                w_q <= '{st: W_INV, tch: 1'b0, rg: '0, dat: '0};
            end else if (sweep_en) begin
                if (sweep_kills(w_q.st, w_q.tch, sweep_mask[w_q.rg]))
                    w_q.st <= W_INV;
                w_q.tch <= 1'b0;
            end else begin
                if (wr_en && wr_addr == AW'(g)) begin
                    w_q.st  <= wr_state;
                    w_q.dat <= wr_data;
                    w_q.rg  <= wr_region;
                end
                if (touch_en && touch_addr == AW'(g))
                    w_q.tch <= 1'b1;
            end
        end

        assign st_vec[g]  = w_q.st;
        assign dat_vec[g] = w_q.dat;
    end

    assign rd_state = st_vec[rd_addr];
    assign rd_data  = dat_vec[rd_addr];

endmodule

// File: rtl/coh_pend_track.sv
module coh_pend_track #(
    parameter int NWORDS = 16,
    localparam int AW    = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [AW-1:0]     set_addr,
    input  logic              clr_en,
    input  logic [AW-1:0]     clr_addr,
    input  logic [AW-1:0]     probe_addr,
    output logic              probe_hit
);

    logic [NWORDS-1:0] pend_q;
    logic [NWORDS-1:0] set_vec, clr_vec;

    assign set_vec = set_en ? (NWORDS'(1) << set_addr) : '0;
    assign clr_vec = clr_en ? (NWORDS'(1) << clr_addr) : '0;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    assign probe_hit = pend_q[probe_addr];

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
    import coh_pkg::*;
#(
    parameter int NWORDS = 16,
    parameter int DW     = 32,
    parameter int NREG   = 4,
    localparam int AW    = $clog2(NWORDS),
    localparam int RW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            core_req_valid,
    input  logic            core_req_write,
    input  logic [AW-1:0]   core_req_addr,
    input  logic [DW-1:0]   core_req_wdata,
    input  logic [RW-1:0]   core_req_region,
    output logic            core_req_ready,
    output logic            accept,
    output logic            fill_busy,
    input  wstate_e         hit_state,
    input  logic [DW-1:0]   hit_data,
    input  logic            pend_hit,
    input  logic            fill_rsp_valid,
    input  logic [DW-1:0]   fill_rsp_data,
    input  logic            phase_end_valid,
    input  logic [NREG-1:0] phase_end_mask,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output wstate_e         wr_state,
    output logic [DW-1:0]   wr_data,
    output logic [RW-1:0]   wr_region,
    output logic            touch_en,
    output logic [AW-1:0]   touch_addr,
    output logic            sweep_en,
    output logic [NREG-1:0] sweep_mask,
    output logic            pend_set,
    output logic            resp_valid_q,
    output logic [DW-1:0]   resp_data_q,
    output logic            fill_req_q,
    output logic [AW-1:0]   fill_addr_q,
    output logic            reg_req_q,
    output logic [AW-1:0]   reg_addr_q,
    output logic            done_q
);

    cstate_e         cs_q;
    logic            pe_pend_q;
    logic [NREG-1:0] pe_mask_q;
    logic [AW-1:0]   miss_addr_q;
    logic [RW-1:0]   miss_rg_q;
    logic            is_miss, fill_done, load_hit, load_miss;

    assign core_req_ready = (cs_q == C_IDLE) && !pe_pend_q && !pend_hit;
    assign accept         = core_req_valid && core_req_ready;
    assign fill_busy      = (cs_q == C_FILL);
    assign is_miss        = (hit_state == W_INV);
    assign load_hit       = accept && !core_req_write && !is_miss;
    assign load_miss      = accept && !core_req_write && is_miss;
    assign fill_done      = (cs_q == C_FILL) && fill_rsp_valid;
    assign sweep_en       = (cs_q == C_IDLE) && pe_pend_q;
    assign sweep_mask     = pe_mask_q;
    assign pend_set       = accept && core_req_write && (hit_state != W_REG);

    always_comb begin
        wr_en      = 1'b0;
        wr_addr    = core_req_addr;
        wr_state   = W_REG;
        wr_data    = core_req_wdata;
        wr_region  = core_req_region;
        touch_en   = load_hit;
        touch_addr = core_req_addr;
        if (accept && core_req_write) begin
            wr_en = 1'b1;
        end else if (fill_done) begin
            wr_en      = 1'b1;
            wr_addr    = miss_addr_q;
            wr_state   = W_VAL;
            wr_data    = fill_rsp_data;
            wr_region  = miss_rg_q;
            touch_en   = 1'b1;
            touch_addr = miss_addr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q         <= C_IDLE;
            pe_pend_q    <= 1'b0;
            pe_mask_q    <= '0;
            miss_addr_q  <= '0;
            miss_rg_q    <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
            fill_req_q   <= 1'b0;
            fill_addr_q  <= '0;
            reg_req_q    <= 1'b0;
            reg_addr_q   <= '0;
            done_q       <= 1'b0;
        end else begin
            resp_valid_q <= (accept && (core_req_write || !is_miss)) || fill_done;
            if (accept && core_req_write) resp_data_q <= core_req_wdata;
            else if (fill_done)           resp_data_q <= fill_rsp_data;
            else if (load_hit)            resp_data_q <= hit_data;
            fill_req_q <= load_miss;
            reg_req_q  <= pend_set;
            done_q     <= sweep_en;
            if (load_miss) begin
                fill_addr_q <= core_req_addr;
                miss_addr_q <= core_req_addr;
                miss_rg_q   <= core_req_region;
                cs_q        <= C_FILL;
            end else if (fill_done) begin
                cs_q <= C_IDLE;
            end
            if (pend_set) reg_addr_q <= core_req_addr;
            if (phase_end_valid) begin
                pe_pend_q <= 1'b1;
                pe_mask_q <= phase_end_mask;
            end else if (sweep_en) begin
                pe_pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/l1_phase_coh.sv
module l1_phase_coh
    import coh_pkg::*;
#(
    parameter int NWORDS  = 16,
    parameter int DW      = 32,
    parameter int NREG    = 4,
    parameter int CIDW    = 4,
    parameter int CORE_ID = 5,
    localparam int AW     = $clog2(NWORDS),
    localparam int RW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            core_req_valid,
    input  logic            core_req_write,
    input  logic [AW-1:0]   core_req_addr,
    input  logic [DW-1:0]   core_req_wdata,
    input  logic [RW-1:0]   core_req_region,
    output logic            core_req_ready,
    output logic            core_resp_valid,
    output logic [DW-1:0]   core_resp_data,
    output logic            fill_req_valid,
    output logic [AW-1:0]   fill_req_addr,
    input  logic            fill_rsp_valid,
    input  logic [DW-1:0]   fill_rsp_data,
    output logic            reg_req_valid,
    output logic [AW-1:0]   reg_req_addr,
    output logic [CIDW-1:0] reg_req_core,
    input  logic            reg_ack_valid,
    input  logic [AW-1:0]   reg_ack_addr,
    input  logic            phase_end_valid,
    input  logic [NREG-1:0] phase_end_mask,
    output logic            phase_end_done
);

    wstate_e         hit_state, wr_state;
    logic [DW-1:0]   hit_data, wr_data;
    logic            pend_hit, accept, fill_busy, hit_miss;
    logic            wr_en, touch_en, sweep_en, pend_set;
    logic [AW-1:0]   wr_addr, touch_addr;
    logic [RW-1:0]   wr_region;
    logic [NREG-1:0] sweep_mask;

    assign hit_miss     = (hit_state == W_INV);
    assign reg_req_core = CIDW'(CORE_ID);

    coh_word_array #(.NWORDS(NWORDS), .DW(DW), .NREG(NREG)) u_array (
        .clk, .rst,
        .rd_addr(core_req_addr), .rd_state(hit_state), .rd_data(hit_data),
        .wr_en, .wr_addr, .wr_state, .wr_data, .wr_region,
        .touch_en, .touch_addr, .sweep_en, .sweep_mask
    );

    coh_pend_track #(.NWORDS(NWORDS)) u_pend (
        .clk, .rst,
        .set_en(pend_set), .set_addr(core_req_addr),
        .clr_en(reg_ack_valid), .clr_addr(reg_ack_addr),
        .probe_addr(core_req_addr), .probe_hit(pend_hit)
    );

    coh_ctrl #(.NWORDS(NWORDS), .DW(DW), .NREG(NREG)) u_ctrl (
        .clk, .rst,
        .core_req_valid, .core_req_write, .core_req_addr, .core_req_wdata,
        .core_req_region, .core_req_ready, .accept, .fill_busy,
        .hit_state, .hit_data, .pend_hit, .fill_rsp_valid, .fill_rsp_data,
        .phase_end_valid, .phase_end_mask,
        .wr_en, .wr_addr, .wr_state, .wr_data, .wr_region,
        .touch_en, .touch_addr, .sweep_en, .sweep_mask, .pend_set,
        .resp_valid_q(core_resp_valid), .resp_data_q(core_resp_data),
        .fill_req_q(fill_req_valid), .fill_addr_q(fill_req_addr),
        .reg_req_q(reg_req_valid), .reg_addr_q(reg_req_addr),
        .done_q(phase_end_done)
    );

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
    parameter int CIDW    = 4,
    parameter int CORE_ID = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            core_req_write,
    input logic            core_req_ready,
    input logic            core_resp_valid,
    input logic            fill_req_valid,
    input logic            reg_req_valid,
    input logic [CIDW-1:0] reg_req_core,
    input logic            phase_end_done,
    input logic            accept,
    input logic            hit_miss,
    input logic            pend_hit,
    input logic            fill_busy
);

    p_fill_after_miss_r2: assert property (@(posedge clk) disable iff (rst)
        accept && !core_req_write && hit_miss |=> fill_req_valid && !core_resp_valid);

    p_hit_resp_r3: assert property (@(posedge clk) disable iff (rst)
        accept && !core_req_write && !hit_miss |=> core_resp_valid && !fill_req_valid);

    p_store_resp_r4: assert property (@(posedge clk) disable iff (rst)
        accept && core_req_write |=> core_resp_valid);

    p_reg_core_r4: assert property (@(posedge clk) disable iff (rst)
        reg_req_valid |-> reg_req_core == CIDW'(CORE_ID));

    p_stall_pend_r5: assert property (@(posedge clk) disable iff (rst)
        pend_hit |-> !core_req_ready);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        phase_end_done |-> !core_resp_valid && !fill_req_valid);

    p_req_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(fill_req_valid && reg_req_valid));

    p_no_accept_fill_r9: assert property (@(posedge clk) disable iff (rst)
        fill_busy |-> !core_req_ready);

endmodule

bind l1_phase_coh coh_checker #(.CIDW(CIDW), .CORE_ID(CORE_ID)) u_chk (
    .clk(clk), .rst(rst), .core_req_write(core_req_write),
    .core_req_ready(core_req_ready), .core_resp_valid(core_resp_valid),
    .fill_req_valid(fill_req_valid), .reg_req_valid(reg_req_valid),
    .reg_req_core(reg_req_core), .phase_end_done(phase_end_done),
    .accept(accept), .hit_miss(hit_miss), .pend_hit(pend_hit),
    .fill_busy(fill_busy)
);

// File: tb/tb_l1_phase_coh.sv
module tb_l1_phase_coh;

    localparam int NW = 16, DW = 32, NREG = 4, CIDW = 4, CID = 5;
    localparam int AW = $clog2(NW), RW = $clog2(NREG);

    logic clk = 0, rst = 1;
    logic core_req_valid = 0, core_req_write = 0;
    logic [AW-1:0] core_req_addr = '0;
    logic [DW-1:0] core_req_wdata = '0;
    logic [RW-1:0] core_req_region = '0;
    logic core_req_ready, core_resp_valid, fill_req_valid, reg_req_valid, phase_end_done;
    logic [DW-1:0] core_resp_data;
    logic [AW-1:0] fill_req_addr, reg_req_addr;
    logic [CIDW-1:0] reg_req_core;
    logic fill_rsp_valid = 0, reg_ack_valid = 0, phase_end_valid = 0;
    logic [DW-1:0] fill_rsp_data = '0;
    logic [AW-1:0] reg_ack_addr = '0;
    logic [NREG-1:0] phase_end_mask = '0;

    int n_chk = 0, n_fail = 0;

    // bench model: 0 Invalid, 1 Valid, 2 Registered
    int          m_st [NW];
    bit          m_t  [NW];
    int          m_rg [NW];
    logic [DW-1:0] m_d [NW];
    bit          m_p  [NW];

    always #5 clk = ~clk;

    l1_phase_coh #(.NWORDS(NW), .DW(DW), .NREG(NREG), .CIDW(CIDW), .CORE_ID(CID)) dut (.*);

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit kills(int a, logic [NREG-1:0] mask);
        return m_st[a] == 1 && !m_t[a] && mask[m_rg[a]];
    endfunction

    task automatic do_ack(int a);
        reg_ack_valid = 1; reg_ack_addr = AW'(a);
        @(negedge clk);
        reg_ack_valid = 0;
        m_p[a] = 0;
    endtask

    task automatic present(int a, bit wr, int rg, logic [DW-1:0] d);
        if (m_p[a]) do_ack(a);
        core_req_valid = 1; core_req_write = wr; core_req_addr = AW'(a);
        core_req_region = RW'(rg); core_req_wdata = d;
        #1;
        chk(core_req_ready == 1, "R5 ready for non-pending word", core_req_ready, 1);
        @(negedge clk);
        core_req_valid = 0;
    endtask

    task automatic do_load(int a, int rg);
        logic [DW-1:0] fd;
        present(a, 0, rg, '0);
        if (m_st[a] == 0) begin
            chk(fill_req_valid && fill_req_addr == AW'(a) && !core_resp_valid,
                "R2 fill request on miss", {fill_req_valid, fill_req_addr}, {1'b1, AW'(a)});
            chk(core_req_ready == 0, "R9 no accept during fill", core_req_ready, 0);
            fd = $urandom;
            @(negedge clk);
            fill_rsp_valid = 1; fill_rsp_data = fd;
            @(negedge clk);
            fill_rsp_valid = 0;
            chk(core_resp_valid && core_resp_data == fd, "R2 fill data returned",
                core_resp_data, fd);
            m_st[a] = 1; m_t[a] = 1; m_rg[a] = rg; m_d[a] = fd;
        end else begin
            chk(core_resp_valid && !fill_req_valid && core_resp_data == m_d[a],
                "R3 hit data", core_resp_data, m_d[a]);
            m_t[a] = 1;
        end
    endtask

    task automatic do_store(int a, int rg, logic [DW-1:0] d);
        bit exp_reg;
        exp_reg = (m_st[a] != 2);
        present(a, 1, rg, d);
        chk(reg_req_valid == exp_reg, "R4 registration request", reg_req_valid, exp_reg);
        if (exp_reg)
            chk(reg_req_addr == AW'(a) && reg_req_core == CIDW'(CID), "R4 registration fields",
                {reg_req_core, reg_req_addr}, {CIDW'(CID), AW'(a)});
        chk(core_resp_valid && core_resp_data == d, "R4 store completion", core_resp_data, d);
        m_st[a] = 2; m_rg[a] = rg; m_d[a] = d;
        if (exp_reg) m_p[a] = 1;
    endtask

    task automatic do_phase(logic [NREG-1:0] mask);
        phase_end_valid = 1; phase_end_mask = mask;
        @(negedge clk);
        phase_end_valid = 0;
        chk(core_req_ready == 0 && phase_end_done == 0, "R8 stalled while sweep pending",
            {core_req_ready, phase_end_done}, 0);
        @(negedge clk);
        chk(phase_end_done == 1, "R8 done pulse", phase_end_done, 1);
        @(negedge clk);
        chk(phase_end_done == 0, "R8 done is one cycle", phase_end_done, 0);
        for (int i = 0; i < NW; i++) begin
            if (kills(i, mask)) m_st[i] = 0;
            m_t[i] = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < NW; i++) begin
            m_st[i] = 0; m_t[i] = 0; m_rg[i] = 0; m_d[i] = '0; m_p[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(core_req_ready && !core_resp_valid && !fill_req_valid && !reg_req_valid
            && !phase_end_done, "R1 reset outputs",
            {core_req_ready, core_resp_valid, fill_req_valid, reg_req_valid, phase_end_done},
            5'b10000);

        // R6 phase 1: touched, registered and unmasked words survive
        do_load(0, 0);
        do_store(1, 0, 32'hAAAA_0001);
        do_load(2, 1);
        do_phase(4'b0001);
        do_ack(1);
        // R7 phase 2: no reads, touched flags were cleared, masked Valid words drop
        do_phase(4'b0011);
        do_load(0, 0);  // R7 expects a miss
        do_load(2, 1);  // R7 expects a miss
        do_load(1, 0);  // R6 registered survives, hit

        // R10 store to a neighbour leaves word 0 intact
        do_store(3, 0, 32'h1234_5678);
        do_ack(3);
        do_load(0, 0);
        do_load(3, 0);

        // R4 store to an already Registered word sends no request
        do_store(3, 2, 32'hBEEF_0003);

        // R5 stall on an outstanding registration
        do_store(4, 1, 32'h0000_4444);
        core_req_valid = 1; core_req_write = 0; core_req_addr = AW'(4);
        #1;
        chk(core_req_ready == 0, "R5 stall on pending word", core_req_ready, 0);
        @(negedge clk);
        chk(core_req_ready == 0, "R5 still stalled", core_req_ready, 0);
        core_req_valid = 0;
        reg_ack_valid = 1; reg_ack_addr = AW'(4);
        @(negedge clk);
        reg_ack_valid = 0; m_p[4] = 0;
        core_req_addr = AW'(4);
        #1;
        chk(core_req_ready == 1, "R5 ready after ack", core_req_ready, 1);
        do_load(4, 1);

        // Coincidence: ack and phase end in the same cycle
        do_store(5, 3, 32'h5555_AAAA);
        reg_ack_valid = 1; reg_ack_addr = AW'(5);
        phase_end_valid = 1; phase_end_mask = 4'b1111;
        @(negedge clk);
        reg_ack_valid = 0; phase_end_valid = 0; m_p[5] = 0;
        chk(core_req_ready == 0, "R8 stall during latched sweep", core_req_ready, 0);
        @(negedge clk);
        chk(phase_end_done == 1, "R8 done with coincident ack", phase_end_done, 1);
        for (int i = 0; i < NW; i++) begin
            if (kills(i, 4'b1111)) m_st[i] = 0;
            m_t[i] = 0;
        end
        @(negedge clk);
        do_load(5, 3);  // R6 registered word survives, no stall

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int a, op;
            a = $urandom % NW;
            op = $urandom % 10;
            if (op < 5)      do_load(a, $urandom % NREG);
            else if (op < 8) do_store(a, $urandom % NREG, $urandom);
            else if (op < 9) do_phase(NREG'($urandom));
            else begin
                for (int i = 0; i < NW; i++) if (m_p[i]) begin do_ack(i); break; end
            end
        end
        for (int i = 0; i < NW; i++) do_load(i, 0);  // R10 final sweep of contents

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule